// File: doc/BRIEF.md
# Six-Phase Non-Overlapping PWM Sequencer

This block drives the six high-side switches of a six-level multi-inductor hybrid buck stage and the six ground-side switches beneath them. Every output channel gets a pulse window inside one shared period. The period length comes from a programmable terminal count, and every window start is derived from that same count. The windows are arranged so that two neighbouring high-side switches (channel k and channel k+1) are never on in the same clock. The duty command is saturated to the largest value that the chosen arrangement can hold without such an overlap.

There are three arrangements. The sequential one spaces the six channels by a sixth of the period. The paired one fires the channels in the order A, D, B, E, C, F with the same sixth-of-a-period spacing, which doubles the permitted duty and keeps six-way interleaving. The two-phase one runs channels A, C and E together and B, D and F half a period later, which allows half the period as duty. Each ground-side output is the complement of its high-side output, with a fixed gap of idle clocks on both edges.

A small controller with states IDLE, RUN and LAST owns the period counter. The transitions are:
- IDLE→RUN when enable is high.
- RUN→RUN at the period wrap while enable stays high.
- RUN→LAST when enable drops mid-period.
- RUN→IDLE when enable is low at the wrap.
- LAST→IDLE at the wrap.

Duty, arrangement and terminal count are captured only on IDLE→RUN and on RUN→RUN wraps.

Top module: `pwm6_seq`

## Requirements
- R1: Each ground-side output `ls_o[k]` is on only while its high-side output is off. After either output turns off, the other one stays off for `DEAD` clocks before it turns on. A high-side pulse request no longer than `DEAD` clocks produces no high-side pulse.
- R2: For every k from 0 to 4, `hs_o[k]` and `hs_o[k+1]` are never high in the same clock, whatever the duty, arrangement or period.
- R3: With `mode` = 2'b00 or 2'b11 (sequential), let P = tc+1 and U = floor(P/6). Channel k's window starts at counter value k·U, and the duty is capped at U.
- R4: With `mode` = 2'b01 (paired), the window starts are A at 0, D at U, B at 2U, E at 3U, C at 4U and F at 5U. The duty is capped at 2U, and channel F's window wraps past the period end.
- R5: With `mode` = 2'b10 (two-phase), channels 0, 2 and 4 start at 0 and channels 1, 3 and 5 start at floor(P/2). The duty is capped at floor(P/2).
- R6: A request window opens at its start count and lasts min(duty, cap) counter values. The high-side on-time per period is therefore min(duty, cap) − `DEAD` clocks, or zero if that is not positive.
- R7: Changes to `duty`, `mode` or `tc` during a period have no effect until the next period boundary (the start from IDLE or a wrap while enabled).
- R8: In IDLE all high-side outputs stay low. Dropping `en` lets the current period finish and then idles the block. Raising `en` again during that final period is ignored.
- R9: `err_o` is a sticky flag that is set if two neighbouring high-side outputs are ever seen high together. In correct operation it stays low.
- R10: During reset all outputs are low. Once reset is released, the ground-side outputs turn on `DEAD` clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request |
| tc | input | CW | Period terminal count (period = tc+1 clocks) |
| duty | input | CW | Duty command in clocks |
| mode | input | 2 | Arrangement: 00/11 sequential, 01 paired, 10 two-phase |
| hs_o | output | 6 | High-side switch drives A..F (bit 0 = A) |
| ls_o | output | 6 | Ground-side switch drives, complements with dead time |
| err_o | output | 1 | Sticky neighbour-overlap flag |

## Verification
Directed runs saturate the duty in each arrangement and measure the on-time of one channel over a full period. This separates the three caps from one another and shows the wrap of channel F in the paired order. Short duties near the dead time show that tiny pulses are suppressed. Random bursts change the terminal count, the arrangement, the duty and the enable at arbitrary cycles, and every clock is compared with a bench model. This catches configuration captured at the wrong moment, wrong window offsets and a stop that does not wait for the period to end. A directed stop with a re-assertion during the final period checks the LAST state.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

    localparam int NCH = 6;

    typedef enum logic [1:0] {
        MODE_SEQ     = 2'b00,
        MODE_PAIR    = 2'b01,
        MODE_DUAL    = 2'b10,
        MODE_SEQ_ALT = 2'b11
    } pwm_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_LAST = 2'b10
    } seq_state_e;

    // Slot index (in units of a sixth of the period) for the A,D,B,E,C,F order
    function automatic int pair_slot(input int ch);
        return (ch < 3) ? 2 * ch : 2 * (ch - 3) + 1;
    endfunction

endpackage

// File: rtl/pwm6_cfg.sv
module pwm6_cfg
    import pwm6_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic [CW-1:0] tc,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] duty,
    output pwm_mode_e     mode_eff,
    output logic [CW-1:0] unit,
    output logic [CW-1:0] half,
    output logic [CW-1:0] duty_sat
);
    localparam int PW = CW + 1;

    logic [PW-1:0] per;
    logic [PW-1:0] unit_full;
    logic [CW-1:0] cap;

    assign per       = {1'b0, tc} + PW'(1);
    assign unit_full = per / PW'(6);
    assign unit      = unit_full[CW-1:0];
    assign half      = per[PW-1:1];

    always_comb begin
        mode_eff = pwm_mode_e'(mode);
        unique case (mode_eff)
            MODE_PAIR: cap = unit << 1;
            MODE_DUAL: cap = half;
            default:   cap = unit;
        endcase
        duty_sat = (duty > cap) ? cap : duty;
    end

endmodule

// File: rtl/pwm6_phase.sv
module pwm6_phase
    import pwm6_pkg::*;
#(
    parameter int CW = 8,
    parameter int CH = 0
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW:0]   per,
    input  logic [CW-1:0] unit,
    input  logic [CW-1:0] half,
    input  logic [CW-1:0] duty,
    input  pwm_mode_e     mode,
    input  logic          active,
    output logic          raw
);
    localparam int PW        = CW + 1;
    localparam int SLOT_SEQ  = CH;
    localparam int SLOT_PAIR = pair_slot(CH);
    localparam bit LATE_HALF = (CH % 2) == 1;

    logic [PW-1:0] start;
    logic [PW-1:0] cnt_w;
    logic [PW-1:0] elapsed;

    always_comb begin
        unique case (mode)
            MODE_PAIR: start = {1'b0, unit} * PW'(SLOT_PAIR);
            MODE_DUAL: start = LATE_HALF ? {1'b0, half} : '0;
            default:   start = {1'b0, unit} * PW'(SLOT_SEQ);
        endcase
    end

    assign cnt_w   = {1'b0, cnt};
    assign elapsed = (cnt_w >= start) ? (cnt_w - start) : (cnt_w + per - start);
    assign raw     = active && (elapsed < {1'b0, duty});

endmodule

// File: rtl/pwm6_dead.sv
module pwm6_dead #(
    parameter int DEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic hs,
    output logic ls
);
    localparam int RW = $clog2(DEAD + 1) + 1;

    logic          lvl_q;
    logic [RW-1:0] run_q;
    logic          settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else begin
            lvl_q <= raw;
            if (raw != lvl_q)
                run_q <= '0;
            else if (run_q != RW'(DEAD))
                run_q <= run_q + RW'(1);
        end
    end

    assign settled = (run_q == RW'(DEAD));
    assign hs      = lvl_q && settled;
    assign ls      = !lvl_q && settled;

    generate
        if (DEAD > 0) begin : g_gap_chk
            assert_dead_gap_hs_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(hs) |-> !ls)
                else $error("ground side turned on without a gap");
            assert_dead_gap_ls_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ls) |-> !hs)
                else $error("high side turned on without a gap");
        end
    endgenerate

endmodule

// File: rtl/pwm6_seq.sv
module pwm6_seq
    import pwm6_pkg::*;
#(
    parameter int CW   = 8,
    parameter int DEAD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] tc,
    input  logic [CW-1:0] duty,
    input  logic [1:0]    mode,
    output logic [5:0]    hs_o,
    output logic [5:0]    ls_o,
    output logic          err_o
);
    seq_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] tc_q, duty_q, unit_q, half_q;
    pwm_mode_e     mode_q;
    logic          err_q;

    pwm_mode_e     mode_in;
    logic [CW-1:0] unit_in, half_in, duty_in;
    logic          wrap, load, active;
    logic [CW:0]   per_q;
    logic [NCH-1:0] raw_w, hs_w, ls_w;

    pwm6_cfg #(.CW(CW)) u_cfg (
        .tc       (tc),
        .mode     (mode),
        .duty     (duty),
        .mode_eff (mode_in),
        .unit     (unit_in),
        .half     (half_in),
        .duty_sat (duty_in)
    );

    assign wrap  = (cnt_q == tc_q);
    assign per_q = {1'b0, tc_q} + (CW + 1)'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and control outputs
    always_comb begin
        st_d   = st_q;
        load   = 1'b0;
        active = 1'b1;
        cnt_d  = wrap ? '0 : cnt_q + CW'(1);
        unique case (st_q)
            ST_IDLE: begin
                active = 1'b0;
                cnt_d  = '0;
                if (en) begin
                    st_d = ST_RUN;
                    load = 1'b1;
                end
            end
            ST_RUN: begin
                if (wrap) begin
                    st_d = en ? ST_RUN : ST_IDLE;
                    load = en;
                end else if (!en) begin
                    st_d = ST_LAST;
                end
            end
            ST_LAST: begin
                if (wrap) st_d = ST_IDLE;
            end
            default: begin
                st_d   = ST_IDLE;
                active = 1'b0;
                cnt_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tc_q   <= '0;
            duty_q <= '0;
            unit_q <= '0;
            half_q <= '0;
            mode_q <= MODE_SEQ;
        end else begin
            cnt_q <= cnt_d;
            if (load) begin
                tc_q   <= tc;
                duty_q <= duty_in;
                unit_q <= unit_in;
                half_q <= half_in;
                mode_q <= mode_in;
            end
        end
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            pwm6_phase #(.CW(CW), .CH(k)) u_phase (
                .cnt    (cnt_q),
                .per    (per_q),
                .unit   (unit_q),
                .half   (half_q),
                .duty   (duty_q),
                .mode   (mode_q),
                .active (active),
                .raw    (raw_w[k])
            );
            pwm6_dead #(.DEAD(DEAD)) u_dead (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (raw_w[k]),
                .hs    (hs_w[k]),
                .ls    (ls_w[k])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (|(hs_w[NCH-2:0] & hs_w[NCH-1:1]));
    end

    assign hs_o  = hs_w;
    assign ls_o  = ls_w;
    assign err_o = err_q;

    assert_adjacent_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_w[NCH-2:0] & hs_w[NCH-1:1]) == '0)
        else $error("neighbouring high-side outputs on together");

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> ($stable(duty_q) && $stable(mode_q) && $stable(tc_q)))
        else $error("configuration changed inside a period");

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (raw_w == '0))
        else $error("pulse request while idle");

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_q)
        else $error("overlap flag raised");

endmodule

// File: tb/pwm6_seq_tb.sv
module pwm6_seq_tb;

    localparam int CW   = 8;
    localparam int DEAD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] tc = 8'd59;
    logic [CW-1:0] duty = '0;
    logic [1:0]    mode = 2'b00;
    logic [5:0]    hs, ls;
    logic          err;

    pwm6_seq #(.CW(CW), .DEAD(DEAD)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tc    (tc),
        .duty  (duty),
        .mode  (mode),
        .hs_o  (hs),
        .ls_o  (ls),
        .err_o (err)
    );

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // Reference model state (0 idle, 1 run, 2 last)
    int m_st, m_cnt, m_P, m_duty, m_mode;
    int m_lvl [6];
    int m_run [6];
    logic [5:0] m_raw;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int f_cap(input int md, input int p);
        if (md == 1) return 2 * (p / 6);
        if (md == 2) return p / 2;
        return p / 6;
    endfunction

    function automatic int f_start(input int md, input int ch, input int p);
        int u = p / 6;
        if (md == 2) return (ch % 2 == 1) ? p / 2 : 0;
        if (md == 1) begin
            case (ch)
                0: return 0;
                3: return u;
                1: return 2 * u;
                4: return 3 * u;
                2: return 4 * u;
                default: return 5 * u;
            endcase
        end
        return ch * u;
    endfunction

    function automatic logic [5:0] exp_hs();
        logic [5:0] v;
        for (int k = 0; k < 6; k++) v[k] = (m_lvl[k] != 0) && (m_run[k] >= DEAD);
        return v;
    endfunction

    function automatic logic [5:0] exp_ls();
        logic [5:0] v;
        for (int k = 0; k < 6; k++) v[k] = (m_lvl[k] == 0) && (m_run[k] >= DEAD);
        return v;
    endfunction

    task automatic m_latch();
        m_P    = int'(tc) + 1;
        m_mode = (int'(mode) == 3) ? 0 : int'(mode);
        m_duty = (int'(duty) > f_cap(m_mode, m_P)) ? f_cap(m_mode, m_P) : int'(duty);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_P = 1; m_duty = 0; m_mode = 0;
            for (int k = 0; k < 6; k++) begin m_lvl[k] = 0; m_run[k] = 0; end
        end else begin
            for (int k = 0; k < 6; k++)
                m_raw[k] = (m_st != 0) &&
                           (((m_cnt - f_start(m_mode, k, m_P) + m_P) % m_P) < m_duty);
            for (int k = 0; k < 6; k++) begin
                if (int'(m_raw[k]) != m_lvl[k]) begin
                    m_lvl[k] = int'(m_raw[k]);
                    m_run[k] = 0;
                end else if (m_run[k] < 1000) begin
                    m_run[k] = m_run[k] + 1;
                end
            end
            case (m_st)
                0: if (en) begin m_latch(); m_st = 1; m_cnt = 0; end
                1: begin
                    if (m_cnt == m_P - 1) begin
                        m_cnt = 0;
                        if (en) m_latch();
                        else m_st = 0;
                    end else begin
                        m_cnt = m_cnt + 1;
                        if (!en) m_st = 2;
                    end
                end
                default: begin
                    if (m_cnt == m_P - 1) begin m_cnt = 0; m_st = 0; end
                    else m_cnt = m_cnt + 1;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(hs == exp_hs(), cur_req, int'(hs), int'(exp_hs()));
            chk(ls == exp_ls(), "R1", int'(ls), int'(exp_ls()));
            chk((hs[4:0] & hs[5:1]) == 5'd0, "R2", int'(hs), 0);
        end
    end

    task automatic measure(input int md, input int dv, input int ch, input int expv,
                           input string req);
        int on_cnt = 0;
        @(negedge clk);
        cur_req = req;
        mode = 2'(md); duty = CW'(dv); en = 1'b1;
        repeat (2 * (int'(tc) + 1) + 4) @(negedge clk);
        repeat (int'(tc) + 1) begin
            @(negedge clk);
            if (hs[ch]) on_cnt++;
        end
        chk(on_cnt == expv, req, on_cnt, expv);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(hs == 6'd0, "R10", int'(hs), 0);
        chk(ls == 6'd0, "R10", int'(ls), 0);
        chk(err == 1'b0, "R10", int'(err), 0);
        rst_n = 1'b1;
        repeat (DEAD + 2) @(negedge clk);
        chk(ls == 6'h3F, "R10", int'(ls), 63);
        cmp_on = 1'b1;

        // Directed caps with P = 60: U = 10, half = 30
        tc = 8'd59;
        measure(0, 200, 0, 10 - DEAD, "R3");
        measure(3, 200, 2, 10 - DEAD, "R3");
        measure(1, 200, 5, 20 - DEAD, "R4");
        measure(1, 200, 3, 20 - DEAD, "R4");
        measure(2, 200, 1, 30 - DEAD, "R5");
        measure(0, 5,   4, 5 - DEAD,  "R6");
        measure(2, 17,  0, 17 - DEAD, "R6");
        measure(0, DEAD, 1, 0,        "R1");

        // Mid-period changes take effect at the boundary only
        cur_req = "R7";
        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            tc   = CW'(11 + ($urandom % 110));
            mode = 2'($urandom % 4);
            duty = CW'($urandom % 128);
            en   = ($urandom % 8) != 0;
            repeat (1 + ($urandom % 120)) @(negedge clk);
        end

        // Stop request, ignored re-enable during the final period
        cur_req = "R8";
        @(negedge clk);
        tc = 8'd59; mode = 2'b00; duty = 8'd200; en = 1'b1;
        repeat (130) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b0;
        repeat (60 + DEAD + 4) @(negedge clk);
        chk(hs == 6'd0, "R8", int'(hs), 0);
        chk(ls == 6'h3F, "R8", int'(ls), 63);

        chk(err == 1'b0, "R9", int'(err), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule